// File: doc/BRIEF.md
# Hot-Plug Expander Synchronisation Controller

This block keeps a switch's per-port hot-plug signals consistent with an external I/O expander on a serial management bus, so the switch spends no dedicated pins on them. It watches a packed vector of hot-plug output values, one group of bits per downstream port; the default build covers four ports. Whenever any bit of that vector changes, it asks an SMBus master engine to write the entire output image to the expander. When the expander pulls its active-low interrupt line, it asks for a read of the entire input image and publishes the result on its hot-plug input vector.

The block talks to the master engine through a request/done handshake. It holds a request, with direction, target address and write data, until the engine returns a one-cycle done pulse, optionally flagged as an error, together with read data. Nothing happens until a configuration-complete input goes high. At that point the block writes the output image once and reads the input image once, so both sides start out consistent. A failed transfer is retried once. A second failure raises a sticky error flag and abandons that transfer.

Top module: `hp_expander_sync`

## Requirements
- R1: While `cfg_done` has never been high since reset, `m_req` stays low and no transfer occurs; after reset `hp_in` is 0 and `err_sticky` is 0.
- R2: When `cfg_done` first goes high, exactly two transfers follow: a write (`m_rnw`=0) that carries the current `hp_out`, then a read (`m_rnw`=1).
- R3: A change of any bit of `hp_out` causes exactly one write whose `m_wdata` equals the whole current `hp_out`; a value equal to the previous one causes no transfer.
- R4: `m_addr` equals `exp_addr` while `m_req` is high, and `m_req`, `m_rnw` and `m_wdata` stay unchanged until the cycle in which `m_done` is seen.
- R5: With `irq_en`=1, a low level on `exp_int_n` starts one read, and `hp_in` takes the value of `m_rdata` when that read completes without error; `hp_in` changes at no other time.
- R6: With `irq_en`=0, a low `exp_int_n` starts no read and leaves `hp_in` unchanged.
- R7: If `exp_int_n` is still low after a read completes, a further read is started.
- R8: At most one transfer is outstanding; when a write and a read are both pending, the write is issued first.
- R9: Any number of `hp_out` changes during an outstanding transfer produce exactly one further write afterwards, carrying the latest `hp_out`.
- R10: A transfer that ends with `m_error`=1 is reissued once with identical direction and data; if the reissue succeeds, `err_sticky` stays 0.
- R11: If the reissue also ends with `m_error`=1, `err_sticky` goes high and stays high until reset, and the transfer is not attempted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_done | input | 1 | Configuration complete; enables all expander traffic |
| irq_en | input | 1 | Enables response to the expander interrupt |
| exp_addr | input | ADDR_W (7) | 7-bit bus address of the expander |
| hp_out | input | NUM_PORTS*OUT_PER_PORT (16) | Hot-plug output image to mirror into the expander |
| exp_int_n | input | 1 | Expander interrupt, active low, asynchronous |
| hp_in | output | NUM_PORTS*IN_PER_PORT (16) | Last input image read from the expander |
| err_sticky | output | 1 | Set after a transfer fails twice; cleared only by reset |
| m_req | output | 1 | Transfer request to the master engine |
| m_rnw | output | 1 | 1 = read, 0 = write |
| m_addr | output | ADDR_W (7) | Target address for the transfer |
| m_wdata | output | NUM_PORTS*OUT_PER_PORT (16) | Output image for a write |
| m_done | input | 1 | One-cycle completion pulse from the master engine |
| m_error | input | 1 | Qualifies `m_done`: the transfer failed |
| m_rdata | input | NUM_PORTS*IN_PER_PORT (16) | Input image returned by a read, valid with `m_done` |

## Verification
The hardest states to reach are those in which work piles up behind a transfer that is still outstanding: output changes and an interrupt arriving while the engine is busy, and a reissued transfer that fails a second time. The bench reaches them with a behavioural master engine whose latency can be stretched and which fails a scripted number of upcoming transfers. It logs every completed transfer, so the order, count and data of the transfers that follow can be compared against the requirements. The interrupt line is released by that model only after a chosen number of reads, which drives the level-sensitive re-read case.

// File: rtl/hpx_pkg.sv
package hpx_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_IDLE = 2'd1,
        ST_BUSY = 2'd2
    } hpx_state_e;

    typedef struct packed {
        hpx_state_e state;
        logic       wr_pend;
        logic       rd_pend;
        logic       redo;
        logic       retry;
        logic       rnw;
        logic       err;
    } hpx_ctl_t;

endpackage

// File: rtl/hpx_irq_sync.sv
module hpx_irq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_n_async,
    input  logic irq_en,
    output logic irq_lvl
);

    logic [STAGES-1:0] sync_d, sync_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], irq_n_async};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign irq_lvl = irq_en & ~sync_q[STAGES-1];

endmodule

// File: rtl/hpx_change_detect.sv
module hpx_change_detect #(
    parameter int NUM_PORTS    = 4,
    parameter int OUT_PER_PORT = 4,
    localparam int OUT_W       = NUM_PORTS * OUT_PER_PORT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic [OUT_W-1:0] vec,
    output logic             changed
);

    logic [OUT_W-1:0]     prev_d, prev_q;
    logic [NUM_PORTS-1:0] port_chg;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        assign port_chg[p] = vec[p*OUT_PER_PORT +: OUT_PER_PORT]
                          != prev_q[p*OUT_PER_PORT +: OUT_PER_PORT];
    end

    always_comb begin
        prev_d  = vec;
        changed = arm & (|port_chg);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

endmodule

// File: rtl/hpx_sched.sv
module hpx_sched
    import hpx_pkg::*;
#(
    parameter int OUT_W       = 16,
    parameter int IN_W        = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_done,
    input  logic             changed,
    input  logic             irq_lvl,
    input  logic [OUT_W-1:0] hp_out,
    input  logic             m_done,
    input  logic             m_error,
    input  logic [IN_W-1:0]  m_rdata,
    output logic             armed,
    output logic             m_req,
    output logic             m_rnw,
    output logic [OUT_W-1:0] m_wdata,
    output logic [IN_W-1:0]  hp_in,
    output logic             err_sticky
);

    localparam int HOLD_W = $clog2(SYNC_STAGES + 1);

    hpx_ctl_t          c_q, c_d;
    logic [OUT_W-1:0]  wdata_d, wdata_q;
    logic [IN_W-1:0]   hin_d, hin_q;
    logic [HOLD_W-1:0] hold_d, hold_q;
    logic              irq_ok;

    always_comb begin
        c_d     = c_q;
        wdata_d = wdata_q;
        hin_d   = hin_q;
        hold_d  = (hold_q != '0) ? hold_q - 1'b1 : '0;
        // interrupt level is ignored until the synchronizer reflects a finished read
        irq_ok  = irq_lvl && (hold_q == '0);

        if (c_q.state != ST_OFF && changed) c_d.wr_pend = 1'b1;

        case (c_q.state)
            ST_OFF: begin
                if (cfg_done) begin
                    c_d.state   = ST_IDLE;
                    c_d.wr_pend = 1'b1;
                    c_d.rd_pend = 1'b1;
                end
            end
            ST_IDLE: begin
                if (c_q.redo) begin
                    c_d.state = ST_BUSY;
                    c_d.redo  = 1'b0;
                    c_d.retry = 1'b1;
                end else if (c_q.wr_pend || changed) begin
                    c_d.state   = ST_BUSY;
                    c_d.rnw     = 1'b0;
                    c_d.retry   = 1'b0;
                    c_d.wr_pend = 1'b0;
                    wdata_d     = hp_out;
                end else if (c_q.rd_pend || irq_ok) begin
                    c_d.state   = ST_BUSY;
                    c_d.rnw     = 1'b1;
                    c_d.retry   = 1'b0;
                    c_d.rd_pend = 1'b0;
                end
            end
            ST_BUSY: begin
                if (m_done) begin
                    c_d.state = ST_IDLE;
                    if (c_q.rnw) hold_d = HOLD_W'(SYNC_STAGES);
                    if (m_error) begin
                        if (!c_q.retry) begin
                            c_d.redo = 1'b1;
                        end else begin
                            c_d.err   = 1'b1;
                            c_d.retry = 1'b0;
                        end
                    end else begin
                        c_d.retry = 1'b0;
                        if (c_q.rnw) hin_d = m_rdata;
                    end
                end
            end
            default: c_d.state = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q     <= '{state: ST_OFF, default: 1'b0};
            wdata_q <= '0;
            hin_q   <= '0;
            hold_q  <= '0;
        end else begin
            c_q     <= c_d;
            wdata_q <= wdata_d;
            hin_q   <= hin_d;
            hold_q  <= hold_d;
        end
    end

    assign armed      = (c_q.state != ST_OFF);
    assign m_req      = (c_q.state == ST_BUSY);
    assign m_rnw      = c_q.rnw;
    assign m_wdata    = wdata_q;
    assign hp_in      = hin_q;
    assign err_sticky = c_q.err;

    // request and its payload hold until completion
    assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && !m_done) |=> (m_req && $stable(m_rnw) && $stable(m_wdata)));

    // input image moves only on a successful read completion
    assert_in_update_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hin_q != $past(hin_q)) |-> $past(m_done && !m_error && m_rnw && m_req));

    // sticky flag only after a failed reissue
    assert_err_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_sticky) |-> $past(m_done && m_error && c_q.retry));

    assert_err_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky |=> err_sticky);

    // a first failure is followed by a return to idle, never the sticky flag
    assert_first_fail_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && m_done && m_error && !c_q.retry) |=> (!m_req && !$rose(err_sticky)));

endmodule

// File: rtl/hp_expander_sync.sv
module hp_expander_sync #(
    parameter int NUM_PORTS    = 4,
    parameter int OUT_PER_PORT = 4,
    parameter int IN_PER_PORT  = 4,
    parameter int ADDR_W       = 7,
    parameter int SYNC_STAGES  = 2,
    localparam int OUT_W       = NUM_PORTS * OUT_PER_PORT,
    localparam int IN_W        = NUM_PORTS * IN_PER_PORT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_done,
    input  logic              irq_en,
    input  logic [ADDR_W-1:0] exp_addr,
    input  logic [OUT_W-1:0]  hp_out,
    input  logic              exp_int_n,
    output logic [IN_W-1:0]   hp_in,
    output logic              err_sticky,
    output logic              m_req,
    output logic              m_rnw,
    output logic [ADDR_W-1:0] m_addr,
    output logic [OUT_W-1:0]  m_wdata,
    input  logic              m_done,
    input  logic              m_error,
    input  logic [IN_W-1:0]   m_rdata
);

    logic irq_lvl;
    logic changed;
    logic armed;

    hpx_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_n_async (exp_int_n),
        .irq_en      (irq_en),
        .irq_lvl     (irq_lvl)
    );

    hpx_change_detect #(
        .NUM_PORTS    (NUM_PORTS),
        .OUT_PER_PORT (OUT_PER_PORT)
    ) u_chg (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (armed),
        .vec     (hp_out),
        .changed (changed)
    );

    hpx_sched #(
        .OUT_W       (OUT_W),
        .IN_W        (IN_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sched (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_done   (cfg_done),
        .changed    (changed),
        .irq_lvl    (irq_lvl),
        .hp_out     (hp_out),
        .m_done     (m_done),
        .m_error    (m_error),
        .m_rdata    (m_rdata),
        .armed      (armed),
        .m_req      (m_req),
        .m_rnw      (m_rnw),
        .m_wdata    (m_wdata),
        .hp_in      (hp_in),
        .err_sticky (err_sticky)
    );

    assign m_addr = exp_addr;

    // independent record of configuration completion
    logic cfg_seen_d, cfg_seen_q;
    always_comb cfg_seen_d = cfg_seen_q | cfg_done;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_seen_q <= 1'b0;
        else        cfg_seen_q <= cfg_seen_d;
    end

    assert_quiet_until_cfg_R1: assert property (@(posedge clk) disable iff (!rst_n)
        m_req |-> cfg_seen_q);

endmodule

// File: tb/hp_expander_sync_tb.sv
module hp_expander_sync_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_done = 1'b0;
    logic        irq_en = 1'b1;
    logic [6:0]  exp_addr = 7'h27;
    logic [15:0] hp_out = 16'h1234;
    logic        exp_int_n = 1'b1;
    logic [15:0] hp_in;
    logic        err_sticky;
    logic        m_req, m_rnw;
    logic [6:0]  m_addr;
    logic [15:0] m_wdata;
    logic        m_done = 1'b0;
    logic        m_error = 1'b0;
    logic [15:0] m_rdata = '0;

    always #2.5 clk = ~clk;

    hp_expander_sync u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done), .irq_en(irq_en),
        .exp_addr(exp_addr), .hp_out(hp_out), .exp_int_n(exp_int_n),
        .hp_in(hp_in), .err_sticky(err_sticky), .m_req(m_req), .m_rnw(m_rnw),
        .m_addr(m_addr), .m_wdata(m_wdata), .m_done(m_done),
        .m_error(m_error), .m_rdata(m_rdata)
    );

    int total = 0, bad = 0;
    int n_tx = 0, addr_bad = 0, req_seen = 0;
    int lat = 3, err_budget = 0, rel_reads = 0;
    logic [15:0] rd_val = 16'h0F0F;
    logic        log_rnw [64];
    logic [15:0] log_wd  [64];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // behavioural master engine
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            if (m_req) req_seen++;
            if (m_done) begin
                m_done  = 1'b0;
                m_error = 1'b0;
            end else if (m_req) begin
                if (m_addr != exp_addr) addr_bad++;
                if (cnt >= lat) begin
                    cnt     = 0;
                    m_done  = 1'b1;
                    m_error = (err_budget > 0);
                    if (err_budget > 0) err_budget--;
                    log_rnw[n_tx % 64] = m_rnw;
                    log_wd[n_tx % 64]  = m_wdata;
                    n_tx++;
                    if (m_rnw) begin
                        m_rdata = rd_val;
                        rd_val  = rd_val + 1'b1;
                        if (rel_reads > 0) begin
                            rel_reads--;
                            if (rel_reads == 0) exp_int_n = 1'b1;
                        end
                    end
                end else begin
                    cnt++;
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog act=0 exp=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    localparam int NV = 6;
    localparam logic [15:0] VEC_VAL [NV] = '{16'h1235, 16'h1235, 16'hFFFF, 16'h0000, 16'h8001, 16'h8001};
    localparam int          VEC_WR  [NV] = '{1, 0, 1, 1, 1, 0};

    initial begin
        int base;
        settle(3);
        // R1 reset state
        chk(hp_in == 16'h0, "R1 hp_in reset", hp_in, 0);
        chk(err_sticky == 1'b0, "R1 err reset", err_sticky, 0);
        rst_n = 1'b1;
        hp_out = 16'h4321;
        exp_int_n = 1'b0;
        settle(20);
        chk(n_tx == 0 && req_seen == 0, "R1 no traffic before cfg", n_tx, 0);
        exp_int_n = 1'b1;
        hp_out = 16'h1234;
        settle(5);

        // R2 initial write then read
        rd_val = 16'h0F0F;
        cfg_done = 1'b1;
        settle(30);
        chk(n_tx == 2, "R2 initial count", n_tx, 2);
        chk(log_rnw[0] == 1'b0 && log_wd[0] == 16'h1234, "R2 first is write of image", {log_rnw[0], log_wd[0]}, 16'h1234);
        chk(log_rnw[1] == 1'b1, "R2 R8 second is read", log_rnw[1], 1);
        chk(hp_in == 16'h0F0F, "R2 R5 initial input image", hp_in, 16'h0F0F);

        // R3 vector table
        for (int i = 0; i < NV; i++) begin
            base = n_tx;
            hp_out = VEC_VAL[i];
            settle(20);
            chk(n_tx - base == VEC_WR[i], "R3 write count", n_tx - base, VEC_WR[i]);
            if (VEC_WR[i] == 1)
                chk(log_rnw[base % 64] == 1'b0 && log_wd[base % 64] == VEC_VAL[i],
                    "R3 write data", log_wd[base % 64], VEC_VAL[i]);
        end
        chk(addr_bad == 0, "R4 address", addr_bad, 0);

        // R5 interrupt read
        base = n_tx;
        rd_val = 16'hA5C3;
        rel_reads = 1;
        exp_int_n = 1'b0;
        settle(25);
        chk(n_tx - base == 1 && log_rnw[base % 64] == 1'b1, "R5 one read", n_tx - base, 1);
        chk(hp_in == 16'hA5C3, "R5 latched input", hp_in, 16'hA5C3);

        // R6 disabled interrupt
        base = n_tx;
        irq_en = 1'b0;
        exp_int_n = 1'b0;
        settle(25);
        chk(n_tx == base, "R6 no read when disabled", n_tx - base, 0);
        chk(hp_in == 16'hA5C3, "R6 input unchanged", hp_in, 16'hA5C3);
        exp_int_n = 1'b1;
        settle(5);
        irq_en = 1'b1;

        // R7 level re-read
        base = n_tx;
        rd_val = 16'h3000;
        rel_reads = 2;
        exp_int_n = 1'b0;
        settle(40);
        chk(n_tx - base == 2, "R7 two reads while low", n_tx - base, 2);
        chk(hp_in == 16'h3001, "R7 latest input", hp_in, 16'h3001);

        // R8 write before read, R9 coalescing during a long transfer
        lat = 8;
        base = n_tx;
        hp_out = 16'h5555;
        wait (m_req === 1'b1);
        settle(2);
        rel_reads = 1;
        rd_val = 16'h7777;
        exp_int_n = 1'b0;
        hp_out = 16'h6666;
        settle(1);
        hp_out = 16'h6667;
        settle(60);
        chk(n_tx - base == 3, "R9 three transfers", n_tx - base, 3);
        chk(log_wd[base % 64] == 16'h5555, "R9 first write", log_wd[base % 64], 16'h5555);
        chk(log_rnw[(base + 1) % 64] == 1'b0 && log_wd[(base + 1) % 64] == 16'h6667,
            "R9 one extra write with latest", log_wd[(base + 1) % 64], 16'h6667);
        chk(log_rnw[(base + 2) % 64] == 1'b1, "R8 read after pending write", log_rnw[(base + 2) % 64], 1);
        chk(hp_in == 16'h7777, "R8 read result", hp_in, 16'h7777);
        lat = 3;

        // R10 single failure retried
        base = n_tx;
        err_budget = 1;
        hp_out = 16'h0ACE;
        settle(30);
        chk(n_tx - base == 2, "R10 retried once", n_tx - base, 2);
        chk(log_wd[base % 64] == 16'h0ACE && log_wd[(base + 1) % 64] == 16'h0ACE && log_rnw[(base + 1) % 64] == 1'b0,
            "R10 identical reissue", log_wd[(base + 1) % 64], 16'h0ACE);
        chk(err_sticky == 1'b0, "R10 no sticky", err_sticky, 0);

        // R11 double failure
        base = n_tx;
        err_budget = 2;
        hp_out = 16'hBEEF;
        settle(40);
        chk(n_tx - base == 2, "R11 dropped after two", n_tx - base, 2);
        chk(err_sticky == 1'b1, "R11 sticky set", err_sticky, 1);
        hp_out = 16'hBEE0;
        settle(20);
        chk(err_sticky == 1'b1, "R11 sticky holds", err_sticky, 1);
        chk(addr_bad == 0, "R4 address overall", addr_bad, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule